// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

A behavioural, synthesizable model of an 18-kilobit dual-clock memory. It holds 512 words, each with 32 data bits and 4 parity bits. Port A reads and writes on its own clock. Port B writes only, on a second clock. Each port picks its width by a parameter: 1, 2 or 4 data bits, 9 bits (one byte plus its parity bit), 18 bits (two bytes plus two parity bits) or 36 bits (four bytes plus four parity bits). A word written through a wide port can be read back piece by piece through a narrow one.

Both ports take a 14-bit bit-granular address. A port whose data width is 2^k bits uses only address bits [13:k]. Port A's read path has a read latch with a synchronous clear, plus an optional output register. That register has its own clock enable and its own clear. A parameter chooses what port A shows while it writes: the new data, the old data, or its previous output unchanged.

Top module: `mwram_mixed`

## Requirements
- R1: For a 36-bit port the word is laid out as follows. Bits [7:0] are byte 0 and [15:8] are byte 1. Bits [17:16] are the parity of bytes 1 and 0. Bits [25:18] are byte 2 and [33:26] are byte 3. Bits [35:34] are the parity of bytes 3 and 2. A 9-bit port at address bits [13:5] (word) and [4:3] (byte n) reads {parity bit n, byte n}, with the parity bit in bit 8.
- R2: A port of 1, 2 or 4 data bits reads bits [i*w +: w] of the word's 32 data bits. Here w is the width and i is the address bits [4:log2 w]. Parity is never visible on such a port.
- R3: Port B's lane enable bit n writes data byte n together with parity bit n. A lane whose bit is 0 keeps its old content.
- R4: A 9-bit or narrower port A writes only when lane enable bit 0 is set. Lane bits [3:1] have no effect at those widths.
- R5: The address bits below a port's granularity have no effect on which data is read.
- R6: With en_a low, port A neither reads nor writes, and its read latch holds. With en_b low, port B does not write.
- R7: In write-first mode, port A's read output shows the newly written word in the cycle of the write.
- R8: In read-first mode, port A's read output shows the word's old content in the cycle of the write.
- R9: In no-change mode, a write on port A leaves its read output at its previous value.
- R10: With one output register stage, the latched data reaches dout_a one clock later, and only in a cycle where regce_a is high. Otherwise the register holds.
- R11: rst_reg_a clears the output register to zero at the next clock, even when regce_a is low.
- R12: rst_latch_a clears the read latch to zero at the next clock when en_a is high. It has no effect when en_a is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| addr_a | input | 14 | Port A bit-granular address |
| en_a | input | 1 | Port A enable for both read and write |
| we_a | input | 4 | Port A lane write enables |
| rst_latch_a | input | 1 | Synchronous clear of the read latch, gated by en_a |
| regce_a | input | 1 | Output register clock enable |
| rst_reg_a | input | 1 | Synchronous clear of the output register, overrides regce_a |
| din_a | input | PWA | Port A write word |
| dout_a | output | PWA | Port A read word |
| clk_b | input | 1 | Port B clock |
| addr_b | input | 14 | Port B bit-granular address |
| en_b | input | 1 | Port B enable |
| we_b | input | 4 | Port B lane write enables |
| din_b | input | PWB | Port B write word |

## Verification
A read and a write can happen on port A in the same cycle. The bench does this by raising the lane enable during an enabled read of a location whose old content it knows. It then compares the output against the new word, the old word, or the previously shown word. Four instances in different modes share the same stimulus, so one stimulus covers every mode. The output register's clear and its clock enable can also be active together. The bench raises both in one cycle while the latch holds nonzero data, and expects zero.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int unsigned WORD_DATA_W = 32;
    localparam int unsigned WORD_PAR_W  = 4;
    localparam int unsigned WORD_W      = WORD_DATA_W + WORD_PAR_W;
    localparam int unsigned SUB_W       = 5;
    localparam int unsigned LANES       = 4;

    typedef enum logic [1:0] {
        WM_WRITE_FIRST,
        WM_READ_FIRST,
        WM_NO_CHANGE
    } wmode_e;

    // Bit masks and values that a port write merges into one stored word.
    typedef struct packed {
        logic [WORD_DATA_W-1:0] dmask;
        logic [WORD_DATA_W-1:0] dval;
        logic [WORD_PAR_W-1:0]  pmask;
        logic [WORD_PAR_W-1:0]  pval;
    } merge_t;

    // Port width in bits: 2^l2 for l2 < 3, else 9 * 2^(l2-3).
    function automatic int unsigned port_width(int unsigned l2);
        return (l2 < 3) ? (32'd1 << l2) : (32'd9 << (l2 - 32'd3));
    endfunction

    function automatic merge_t place(int unsigned l2, logic [4:0] sub,
                                     logic [35:0] pw, logic [3:0] lanes);
        merge_t      m;
        logic [31:0] wmask;
        logic [4:0]  off;
        m = '0;
        if (l2 < 3) begin
            wmask = (32'd1 << (32'd1 << l2)) - 32'd1;
            off   = sub & ~5'((1 << l2) - 1);
            if (lanes[0]) begin
                m.dmask = wmask << off;
                m.dval  = (pw[31:0] & wmask) << off;
            end
        end else if (l2 == 3) begin
            off = {sub[4:3], 3'b000};
            if (lanes[0]) begin
                m.dmask = 32'hFF << off;
                m.dval  = {24'h0, pw[7:0]} << off;
                m.pmask = 4'b0001 << sub[4:3];
                m.pval  = {3'b000, pw[8]} << sub[4:3];
            end
        end else if (l2 == 4) begin
            off     = {sub[4], 4'b0000};
            m.dmask = {16'h0, {8{lanes[1]}}, {8{lanes[0]}}} << off;
            m.dval  = {16'h0, pw[15:0]} << off;
            m.pmask = {2'b00, lanes[1:0]} << {sub[4], 1'b0};
            m.pval  = {2'b00, pw[17:16]} << {sub[4], 1'b0};
        end else begin
            m.dmask = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
            m.dval  = {pw[33:18], pw[15:0]};
            m.pmask = lanes;
            m.pval  = {pw[35:34], pw[17:16]};
        end
        return m;
    endfunction

    function automatic logic [35:0] pick(int unsigned l2, logic [4:0] sub,
                                         logic [31:0] d, logic [3:0] p);
        logic [31:0] sh;
        logic [4:0]  off;
        if (l2 < 3) begin
            off = sub & ~5'((1 << l2) - 1);
            sh  = d >> off;
            return {4'h0, sh & ((32'd1 << (32'd1 << l2)) - 32'd1)};
        end else if (l2 == 3) begin
            sh = d >> {sub[4:3], 3'b000};
            return {27'h0, p[sub[4:3]], sh[7:0]};
        end else if (l2 == 4) begin
            sh = d >> {sub[4], 4'b0000};
            return {18'h0, (sub[4] ? p[3:2] : p[1:0]), sh[15:0]};
        end
        return {p[3:2], d[31:16], p[1:0], d[15:0]};
    endfunction

endpackage

// File: rtl/mwram_bank.sv
module mwram_bank #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];

endmodule

// File: rtl/mwram_rd_port.sv
module mwram_rd_port import mwram_pkg::*; #(
    parameter int unsigned PW         = 9,
    parameter int unsigned REG_STAGES = 1,
    parameter wmode_e      WRITE_MODE = WM_WRITE_FIRST
) (
    input  logic          clk,
    input  logic          en,
    input  logic          wr,
    input  logic          rst_latch,
    input  logic          regce,
    input  logic          rst_reg,
    input  logic [PW-1:0] old_word,
    input  logic [PW-1:0] new_word,
    output logic [PW-1:0] dout
);
    typedef struct packed {
        logic [PW-1:0] latch;
        logic [PW-1:0] oreg;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (rst_latch) begin
                st_d.latch = '0;
            end else if (!wr) begin
                st_d.latch = old_word;
            end else begin
                case (WRITE_MODE)
                    WM_WRITE_FIRST: st_d.latch = new_word;
                    WM_READ_FIRST:  st_d.latch = old_word;
                    default:        st_d.latch = st_q.latch;
                endcase
            end
        end
        if (rst_reg) begin
            st_d.oreg = '0;
        end else if (regce) begin
            st_d.oreg = st_q.latch;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    generate
        if (REG_STAGES != 0) begin : g_reg
            assign dout = st_q.oreg;
        end else begin : g_noreg
            assign dout = st_q.latch;
        end
    endgenerate

endmodule

// File: rtl/mwram_mixed.sv
module mwram_mixed import mwram_pkg::*; #(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned A_LOG2     = 3,
    parameter int unsigned B_LOG2     = 5,
    parameter int unsigned REG_STAGES = 1,
    parameter wmode_e      WRITE_MODE = WM_WRITE_FIRST,
    localparam int unsigned PWA       = port_width(A_LOG2),
    localparam int unsigned PWB       = port_width(B_LOG2)
) (
    input  logic              clk_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              en_a,
    input  logic [LANES-1:0]  we_a,
    input  logic              rst_latch_a,
    input  logic              regce_a,
    input  logic              rst_reg_a,
    input  logic [PWA-1:0]    din_a,
    output logic [PWA-1:0]    dout_a,
    input  logic              clk_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              en_b,
    input  logic [LANES-1:0]  we_b,
    input  logic [PWB-1:0]    din_b
);
    localparam int unsigned WORD_AW = ADDR_W - SUB_W;
    localparam int unsigned NBANK   = 2;

    logic [WORD_AW-1:0] word_a, word_b;
    logic [SUB_W-1:0]   sub_a, sub_b;
    logic               wr_a, wr_b;
    logic [WORD_W-1:0]  cur_a, cur_b, upd_a, upd_b;
    merge_t             mrg_a, mrg_b;
    logic [PWA-1:0]     old_a, new_a;

    logic               bank_clk   [NBANK];
    logic               bank_we    [NBANK];
    logic [WORD_AW-1:0] bank_waddr [NBANK];
    logic [WORD_W-1:0]  bank_wdata [NBANK];
    logic [WORD_W-1:0]  bank_at_a  [NBANK];
    logic [WORD_W-1:0]  bank_at_b  [NBANK];

    assign word_a = addr_a[ADDR_W-1:SUB_W];
    assign sub_a  = addr_a[SUB_W-1:0];
    assign word_b = addr_b[ADDR_W-1:SUB_W];
    assign sub_b  = addr_b[SUB_W-1:0];
    assign wr_a   = en_a && (|we_a);
    assign wr_b   = en_b && (|we_b);

    // Stored word = XOR of both banks; each bank has a single writer clock.
    always_comb begin
        cur_a = bank_at_a[0] ^ bank_at_a[1];
        cur_b = bank_at_b[0] ^ bank_at_b[1];
        mrg_a = place(A_LOG2, sub_a, WORD_W'(din_a), we_a);
        mrg_b = place(B_LOG2, sub_b, WORD_W'(din_b), we_b);
        upd_a = {(cur_a[WORD_W-1:WORD_DATA_W] & ~mrg_a.pmask) | (mrg_a.pval & mrg_a.pmask),
                 (cur_a[WORD_DATA_W-1:0] & ~mrg_a.dmask) | (mrg_a.dval & mrg_a.dmask)};
        upd_b = {(cur_b[WORD_W-1:WORD_DATA_W] & ~mrg_b.pmask) | (mrg_b.pval & mrg_b.pmask),
                 (cur_b[WORD_DATA_W-1:0] & ~mrg_b.dmask) | (mrg_b.dval & mrg_b.dmask)};
    end

    assign bank_clk[0]   = clk_a;
    assign bank_we[0]    = wr_a;
    assign bank_waddr[0] = word_a;
    assign bank_wdata[0] = upd_a ^ bank_at_a[1];
    assign bank_clk[1]   = clk_b;
    assign bank_we[1]    = wr_b;
    assign bank_waddr[1] = word_b;
    assign bank_wdata[1] = upd_b ^ bank_at_b[0];

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            mwram_bank #(
                .AW (WORD_AW),
                .DW (WORD_W)
            ) i_bank (
                .clk       (bank_clk[g]),
                .wr_en     (bank_we[g]),
                .wr_addr   (bank_waddr[g]),
                .wr_data   (bank_wdata[g]),
                .rd_addr_a (word_a),
                .rd_data_a (bank_at_a[g]),
                .rd_addr_b (word_b),
                .rd_data_b (bank_at_b[g])
            );
        end
    endgenerate

    assign old_a = PWA'(pick(A_LOG2, sub_a, cur_a[WORD_DATA_W-1:0], cur_a[WORD_W-1:WORD_DATA_W]));
    assign new_a = PWA'(pick(A_LOG2, sub_a, upd_a[WORD_DATA_W-1:0], upd_a[WORD_W-1:WORD_DATA_W]));

    mwram_rd_port #(
        .PW         (PWA),
        .REG_STAGES (REG_STAGES),
        .WRITE_MODE (WRITE_MODE)
    ) i_rd_port (
        .clk       (clk_a),
        .en        (en_a),
        .wr        (wr_a),
        .rst_latch (rst_latch_a),
        .regce     (regce_a),
        .rst_reg   (rst_reg_a),
        .old_word  (old_a),
        .new_word  (new_a),
        .dout      (dout_a)
    );

endmodule

// File: rtl/mwram_chk.sv
module mwram_chk import mwram_pkg::*; #(
    parameter int unsigned PW         = 9,
    parameter int unsigned REG_STAGES = 1,
    parameter wmode_e      WRITE_MODE = WM_WRITE_FIRST
) (
    input logic          clk_a,
    input logic          en_a,
    input logic [3:0]    we_a,
    input logic          rst_latch_a,
    input logic          regce_a,
    input logic          rst_reg_a,
    input logic [PW-1:0] dout_a
);
    generate
        if (REG_STAGES != 0) begin : g_reg
            AST_REG_CLEAR_WINS: assert property (@(posedge clk_a)
                rst_reg_a |=> (dout_a == '0)); // R11
            AST_REG_HOLDS: assert property (@(posedge clk_a) disable iff (rst_reg_a)
                (!regce_a && !rst_reg_a) |=> $stable(dout_a)); // R10
        end else begin : g_noreg
            AST_LATCH_CLEAR: assert property (@(posedge clk_a) disable iff (rst_reg_a)
                (en_a && rst_latch_a) |=> (dout_a == '0)); // R12
            AST_IDLE_HOLDS: assert property (@(posedge clk_a) disable iff (rst_reg_a)
                !en_a |=> $stable(dout_a)); // R6
            if (WRITE_MODE == WM_NO_CHANGE) begin : g_nc
                AST_NOCHANGE_HOLDS: assert property (@(posedge clk_a) disable iff (rst_reg_a)
                    (en_a && (|we_a) && !rst_latch_a) |=> $stable(dout_a)); // R9
            end
        end
    endgenerate
endmodule

bind mwram_mixed mwram_chk #(
    .PW         (PWA),
    .REG_STAGES (REG_STAGES),
    .WRITE_MODE (WRITE_MODE)
) i_chk (
    .clk_a       (clk_a),
    .en_a        (en_a),
    .we_a        (we_a),
    .rst_latch_a (rst_latch_a),
    .regce_a     (regce_a),
    .rst_reg_a   (rst_reg_a),
    .dout_a      (dout_a)
);

// File: tb/test_mwram_mixed.sv
module test_mwram_mixed;
    import mwram_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic        clk_a, clk_b;
    logic [13:0] addr_a = '0, addr_b = '0;
    logic        en_a = 0, en_b = 0, rst_latch_a = 0, regce_a = 0, rst_reg_a = 0;
    logic [3:0]  we_a = '0, we_b = '0;
    logic [8:0]  din_a = '0;
    logic [3:0]  din_a4 = '0;
    logic [35:0] din_b = '0;
    logic [8:0]  dq_wf, dq_rf, dq_nc;
    logic [3:0]  dq_nib;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    initial clk_a = 0;
    always #(CLK_PERIOD / 2) clk_a = ~clk_a;
    initial begin
        clk_b = 0;
        #2;
        forever #(CLK_PERIOD / 2) clk_b = ~clk_b;
    end

    mwram_mixed #(.A_LOG2(3), .B_LOG2(5), .REG_STAGES(1), .WRITE_MODE(WM_WRITE_FIRST)) i_mwram_mixed (
        .clk_a(clk_a), .addr_a(addr_a), .en_a(en_a), .we_a(we_a), .rst_latch_a(rst_latch_a),
        .regce_a(regce_a), .rst_reg_a(rst_reg_a), .din_a(din_a), .dout_a(dq_wf),
        .clk_b(clk_b), .addr_b(addr_b), .en_b(en_b), .we_b(we_b), .din_b(din_b));
    mwram_mixed #(.A_LOG2(3), .B_LOG2(5), .REG_STAGES(0), .WRITE_MODE(WM_READ_FIRST)) i_mwram_rf (
        .clk_a(clk_a), .addr_a(addr_a), .en_a(en_a), .we_a(we_a), .rst_latch_a(rst_latch_a),
        .regce_a(regce_a), .rst_reg_a(rst_reg_a), .din_a(din_a), .dout_a(dq_rf),
        .clk_b(clk_b), .addr_b(addr_b), .en_b(en_b), .we_b(we_b), .din_b(din_b));
    mwram_mixed #(.A_LOG2(3), .B_LOG2(5), .REG_STAGES(0), .WRITE_MODE(WM_NO_CHANGE)) i_mwram_nc (
        .clk_a(clk_a), .addr_a(addr_a), .en_a(en_a), .we_a(we_a), .rst_latch_a(rst_latch_a),
        .regce_a(regce_a), .rst_reg_a(rst_reg_a), .din_a(din_a), .dout_a(dq_nc),
        .clk_b(clk_b), .addr_b(addr_b), .en_b(en_b), .we_b(we_b), .din_b(din_b));
    mwram_mixed #(.A_LOG2(2), .B_LOG2(5), .REG_STAGES(0), .WRITE_MODE(WM_WRITE_FIRST)) i_mwram_nib (
        .clk_a(clk_a), .addr_a(addr_a), .en_a(en_a), .we_a(we_a), .rst_latch_a(rst_latch_a),
        .regce_a(regce_a), .rst_reg_a(rst_reg_a), .din_a(din_a4), .dout_a(dq_nib),
        .clk_b(clk_b), .addr_b(addr_b), .en_b(en_b), .we_b(we_b), .din_b(din_b));

    // Test word written through port B in the first scenario.
    localparam logic [7:0] B0 = 8'hA1, B1 = 8'hB2, B2 = 8'hC3, B3 = 8'hD4;
    localparam logic [3:0] PB = 4'b1010;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] at(int w, int n, logic [2:0] low);
        return 14'((w << 5) | (n << 3) | int'(low));
    endfunction

    function automatic logic [35:0] bword(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                                          logic [7:0] b3, logic [3:0] p);
        return {p[3:2], b3, b2, p[1:0], b1, b0};
    endfunction

    task automatic b_write(input logic [13:0] a, input logic [35:0] w, input logic [3:0] ln,
                           input logic en);
        @(negedge clk_b);
        addr_b = a; din_b = w; we_b = ln; en_b = en;
        @(negedge clk_b);
        en_b = 0; we_b = '0;
    endtask

    // Two enabled cycles with regce high; all outputs sampled after the second.
    task automatic a_read(input logic [13:0] a);
        @(negedge clk_a);
        addr_a = a; en_a = 1; we_a = '0; regce_a = 1;
        @(negedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic a_read_end();
        en_a = 0; regce_a = 0;
    endtask

    task automatic t_reset();
        @(negedge clk_a);
        rst_reg_a = 1; rst_latch_a = 1; en_a = 1;
        @(negedge clk_a);
        check("R11 register clear", 36'(dq_wf), 36'h0);
        check("R12 latch clear rf", 36'(dq_rf), 36'h0);
        check("R12 latch clear nc", 36'(dq_nc), 36'h0);
        rst_reg_a = 0; rst_latch_a = 0; en_a = 0;
    endtask

    task automatic t_width();
        b_write(at(3, 0, 3'b111), bword(B0, B1, B2, B3, PB), 4'hF, 1'b1);
        for (int n = 0; n < 4; n++) begin
            logic [7:0] bn;
            bn = (n == 0) ? B0 : (n == 1) ? B1 : (n == 2) ? B2 : B3;
            a_read(at(3, n, 3'b111));
            check("R1 byte via 9-bit port", 36'(dq_wf), 36'({PB[n], bn}));
            check("R1 byte via 9-bit port rf", 36'(dq_rf), 36'({PB[n], bn}));
            check("R2 high nibble via 4-bit port", 36'(dq_nib), 36'(bn[7:4]));
            a_read_end();
        end
        a_read(at(3, 2, 3'b000));
        check("R5 low address bits ignored", 36'(dq_wf), 36'({PB[2], B2}));
        check("R5 R2 low nibble", 36'(dq_nib), 36'(B2[3:0]));
        a_read_end();
    endtask

    task automatic t_lanes();
        b_write(at(3, 0, 3'b111), bword(8'h11, 8'h22, 8'h33, 8'h44, 4'b0101), 4'b0100, 1'b1);
        a_read(at(3, 2, 3'b111));
        check("R3 enabled lane written", 36'(dq_wf), 36'h133);
        a_read_end();
        a_read(at(3, 1, 3'b111));
        check("R3 disabled lane kept", 36'(dq_wf), 36'({PB[1], B1}));
        a_read_end();
        b_write(at(3, 0, 3'b111), 36'h0, 4'hF, 1'b0);
        a_read(at(3, 0, 3'b111));
        check("R6 en_b low blocks write", 36'(dq_wf), 36'({PB[0], B0}));
        a_read_end();
    endtask

    task automatic t_hold();
        @(negedge clk_a);
        en_a = 0; regce_a = 0; addr_a = at(3, 1, 3'b111);
        @(negedge clk_a);
        @(negedge clk_a);
        check("R6 en_a low holds wf", 36'(dq_wf), 36'({PB[0], B0}));
        check("R6 en_a low holds rf", 36'(dq_rf), 36'({PB[0], B0}));
        check("R6 en_a low holds nc", 36'(dq_nc), 36'({PB[0], B0}));
        en_a = 1;
        @(negedge clk_a);
        check("R10 latch updated", 36'(dq_rf), 36'({PB[1], B1}));
        check("R10 register holds without regce", 36'(dq_wf), 36'({PB[0], B0}));
        en_a = 0; regce_a = 1;
        @(negedge clk_a);
        check("R10 register loads with regce", 36'(dq_wf), 36'({PB[1], B1}));
        regce_a = 0;
    endtask

    task automatic t_a_write();
        @(negedge clk_a);
        addr_a = at(5, 1, 3'b111); din_a = 9'h15A; din_a4 = 4'h9; we_a = 4'b0001; en_a = 1;
        @(negedge clk_a);
        en_a = 0; we_a = '0;
        a_read(at(5, 1, 3'b111));
        check("R4 port A byte write", 36'(dq_wf), 36'h15A);
        check("R4 port A nibble write", 36'(dq_nib), 36'h9);
        a_read_end();
        @(negedge clk_a);
        din_a = 9'h0FF; din_a4 = 4'h0; we_a = 4'b1110; en_a = 1;
        @(negedge clk_a);
        en_a = 0; we_a = '0;
        a_read(at(5, 1, 3'b111));
        check("R4 upper lanes ignored", 36'(dq_wf), 36'h15A);
        check("R4 upper lanes ignored nib", 36'(dq_nib), 36'h9);
        a_read_end();
    endtask

    task automatic t_modes();
        a_read(at(3, 0, 3'b111));
        a_read_end();
        @(negedge clk_a);
        addr_a = at(3, 1, 3'b111); din_a = 9'h077; din_a4 = 4'h6;
        we_a = 4'b0001; en_a = 1; regce_a = 1;
        @(negedge clk_a);
        check("R8 read-first shows old", 36'(dq_rf), 36'({PB[1], B1}));
        check("R9 no-change keeps output", 36'(dq_nc), 36'({PB[0], B0}));
        check("R7 write-first shows new nibble", 36'(dq_nib), 36'h6);
        en_a = 0; we_a = '0;
        @(negedge clk_a);
        check("R7 write-first shows new byte", 36'(dq_wf), 36'h077);
        regce_a = 0;
        a_read(at(3, 1, 3'b111));
        check("R8 stored after read-first", 36'(dq_rf), 36'h077);
        a_read_end();
    endtask

    task automatic t_regrst();
        @(negedge clk_a);
        rst_reg_a = 1; regce_a = 0; en_a = 0;
        @(negedge clk_a);
        check("R11 clear with regce low", 36'(dq_wf), 36'h0);
        addr_a = at(3, 1, 3'b111); en_a = 1; regce_a = 1;
        @(negedge clk_a);
        @(negedge clk_a);
        check("R11 clear wins over regce", 36'(dq_wf), 36'h0);
        rst_reg_a = 0; en_a = 0;
        @(negedge clk_a);
        check("R10 register reloads after clear", 36'(dq_wf), 36'h077);
        regce_a = 0;
    endtask

    task automatic t_latch_rst();
        @(negedge clk_a);
        rst_latch_a = 1; en_a = 0; regce_a = 0;
        @(negedge clk_a);
        check("R12 ignored with en_a low", 36'(dq_rf), 36'h077);
        en_a = 1;
        @(negedge clk_a);
        check("R12 latch clear rf", 36'(dq_rf), 36'h0);
        check("R12 latch clear nc", 36'(dq_nc), 36'h0);
        rst_latch_a = 0; en_a = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk_a);
        t_reset();
        t_width();
        t_lanes();
        t_hold();
        t_a_write();
        t_modes();
        t_regrst();
        t_latch_rst();
        repeat (2) @(negedge clk_a);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule